// File: doc/BRIEF.md
# Serial DAC Write Frame Transmitter

This block sits on the host side of a serial link to a 16-bit voltage-output converter. A client hands it one 16-bit output code and a 2-bit operating-mode field through a valid/ready handshake. The block then drives an active-low frame strobe, an idle-low serial clock and a serial data line. It shifts out a 24-bit word, most significant bit first, and the converter takes each bit on a falling clock edge. After the frame it holds the strobe high for a set gap, and only then takes the next request.

All timing is counted in system clock cycles and set by parameters: the strobe-to-first-edge setup, the length of each clock phase and the gap between frames. Elaboration-time checks reject any setting whose time in nanoseconds falls below the converter's minimums for the chosen supply range. Data moves only when the serial clock rises, so each bit is stable for a full clock phase before and after the falling edge that samples it. An abort input ends a frame early. The strobe goes high before the 24th falling edge, so the converter discards the partial word. The gap before the next frame still applies.

Top module: `sdac_frame_tx`

## Requirements
- R1: The frame is 24 bits, sent MSB first: 6 zero bits, then `in_mode[1]`, `in_mode[0]`, then `in_code[15]` down to `in_code[0]`. Bit k of the frame is the value of `sdo` at the k-th falling edge of `sclk` inside the frame.
- R2: `in_ready` is 1 only when the block is idle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` drops in the next cycle. While `in_ready` is 0, `in_valid`, `in_code` and `in_mode` have no effect.
- R3: In the cycle after acceptance, `sync_n` goes to 0. `sclk` then stays 0 for exactly SETUP_CYC cycles before its first rise.
- R4: Each high phase and each low phase of `sclk` inside a frame lasts exactly HALF_CYC cycles. `sdo` changes inside a frame only in cycles where `sclk` has just risen.
- R5: `sync_n` stays 0 from the cycle after acceptance until HALF_CYC cycles after the 24th falling edge, and then returns to 1.
- R6: `done` is a one-cycle pulse, high in the first cycle after the 24th falling edge of `sclk`. It is never high at any other time.
- R7: After a frame ends or is aborted, `sync_n` stays 1 for GAP_CYC cycles before `in_ready` returns. This gives at least GAP_CYC+1 high cycles between two frames.
- R8: If `abort` is 1 on an edge while `sync_n` is 0, then in the next cycle `sync_n` is 1, `sclk` is 0 and `sdo` is 0. No `done` follows, and the gap of R7 starts.
- R9: `abort` has no effect while `sync_n` is 1, both when idle and during the gap.
- R10: Elaboration fails unless HALF_CYC and SETUP_CYC times the system period are at least 13 ns. It also fails unless the serial clock period and the strobe-high time reach the supply-range minimums: 33.3 ns and 33 ns at the higher supply, 50 ns and 50 ns at the lower.
- R11: After reset, `sync_n` is 1, `sclk` is 0, `sdo` is 0, `done` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept |
| in_code | input | CODE_W | Output code to send |
| in_mode | input | MODE_W | Operating-mode field to send |
| abort | input | 1 | Cancel the frame in progress |
| sync_n | output | 1 | Frame strobe, low during a frame |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, sampled on falling `sclk` |
| done | output | 1 | Pulse after the last falling edge |

## Verification
The hardest cases to reach from the ports are an abort that lands in the same cycle as a phase boundary, and an abort that lands exactly on the final falling edge, where it must suppress `done`. The stimulus sweeps the abort delay one cycle at a time across the setup window, the first bits and the end of a frame. A behavioural cycle model in the bench predicts every output on every cycle. Separate edge-based monitors decode the word from the falling edges and measure phase and gap lengths.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_GAP   = 2'd3
   } tx_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction
endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sdac_frame_shreg.sv
module sdac_frame_shreg #(
   parameter int PAD_W  = 6,
   parameter int MODE_W = 2,
   parameter int CODE_W = 16,
   localparam int FRAME_W = PAD_W + MODE_W + CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   input  logic [MODE_W-1:0] mode,
   input  logic              shift,
   output logic              msb
);
   logic [FRAME_W-1:0] word;
   logic [FRAME_W-1:0] fill;

   generate
      if (PAD_W > 0) begin : g_padded
         assign fill = {{PAD_W{1'b0}}, mode, code};
      end else begin : g_unpadded
         assign fill = {mode, code};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         word <= '0;
      else if (load)
         word <= fill;
      else if (shift)
         word <= {word[FRAME_W-2:0], 1'b0};
   end

   assign msb = word[FRAME_W-1];
endmodule

// File: rtl/sdac_frame_tx.sv
module sdac_frame_tx
   import sdac_pkg::*;
#(
   parameter int CODE_W     = 16,
   parameter int MODE_W     = 2,
   parameter int PAD_W      = 6,
   parameter int CLK_PS     = 10000,
   parameter bit LOW_SUPPLY = 1'b0,
   parameter int HALF_CYC   = 2,
   parameter int SETUP_CYC  = 2,
   parameter int GAP_CYC    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CODE_W-1:0] in_code,
   input  logic [MODE_W-1:0] in_mode,
   input  logic              abort,
   output logic              sync_n,
   output logic              sclk,
   output logic              sdo,
   output logic              done
);
   localparam int FRAME_W   = PAD_W + MODE_W + CODE_W;
   localparam int BIT_W     = $clog2(FRAME_W);
   localparam int MAX_CYC   = max3(HALF_CYC, SETUP_CYC, GAP_CYC);
   localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam int PHASE_MIN = 13000;
   localparam int PER_MIN   = LOW_SUPPLY ? 50000 : 33334;
   localparam int GAP_MIN   = LOW_SUPPLY ? 50000 : 33000;

   // R10: timing minimums checked at elaboration
   generate
      if (HALF_CYC < 1 || SETUP_CYC < 1 || GAP_CYC < 1) begin : g_bad_zero
         $error("cycle counts must be at least one");
      end
      if (HALF_CYC * CLK_PS < PHASE_MIN) begin : g_bad_phase
         $error("serial clock phase shorter than 13 ns");
      end
      if (2 * HALF_CYC * CLK_PS < PER_MIN) begin : g_bad_period
         $error("serial clock faster than the supply range allows");
      end
      if (SETUP_CYC * CLK_PS < PHASE_MIN) begin : g_bad_setup
         $error("strobe setup shorter than 13 ns");
      end
      if ((GAP_CYC + 1) * CLK_PS < GAP_MIN) begin : g_bad_gap
         $error("strobe high time below the supply range minimum");
      end
   endgenerate

   tx_state_e        state;
   logic             hi_phase;
   logic [BIT_W-1:0] bit_idx;
   logic             t_zero;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             sh_msb;

   logic accept, framing, kill, last_bit;
   logic rise_now, fall_now, end_now, gap_start, gap_over;

   always_comb begin
      accept    = (state == ST_IDLE) && in_valid;
      framing   = (state == ST_SETUP) || (state == ST_SHIFT);
      kill      = framing && abort;
      last_bit  = (bit_idx == BIT_W'(FRAME_W - 1));
      rise_now  = !kill && t_zero &&
                  ((state == ST_SETUP) ||
                   ((state == ST_SHIFT) && !hi_phase && !last_bit));
      fall_now  = !kill && t_zero && (state == ST_SHIFT) && hi_phase;
      end_now   = !kill && t_zero && (state == ST_SHIFT) && !hi_phase && last_bit;
      gap_start = kill || end_now;
      gap_over  = (state == ST_GAP) && t_zero;

      t_load = accept || rise_now || fall_now || gap_start;
      if (accept)
         t_val = CNT_W'(SETUP_CYC - 1);
      else if (gap_start)
         t_val = CNT_W'(GAP_CYC - 1);
      else
         t_val = CNT_W'(HALF_CYC - 1);
   end

   sdac_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   sdac_frame_shreg #(
      .PAD_W  (PAD_W),
      .MODE_W (MODE_W),
      .CODE_W (CODE_W)
   ) u_shreg (
      .clk   (clk),
      .rst   (rst),
      .load  (accept),
      .code  (in_code),
      .mode  (in_mode),
      .shift (rise_now),
      .msb   (sh_msb)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         sync_n   <= 1'b1;
         sclk     <= 1'b0;
         sdo      <= 1'b0;
         done     <= 1'b0;
         hi_phase <= 1'b0;
         bit_idx  <= '0;
      end else begin
         done <= fall_now && last_bit;
         if (accept) begin
            state  <= ST_SETUP;
            sync_n <= 1'b0;
         end else if (gap_start) begin
            state    <= ST_GAP;
            sync_n   <= 1'b1;
            sclk     <= 1'b0;
            sdo      <= 1'b0;
            hi_phase <= 1'b0;
         end else if (rise_now) begin
            state    <= ST_SHIFT;
            sclk     <= 1'b1;
            hi_phase <= 1'b1;
            sdo      <= sh_msb;
            bit_idx  <= (state == ST_SETUP) ? '0 : bit_idx + 1'b1;
         end else if (fall_now) begin
            sclk     <= 1'b0;
            hi_phase <= 1'b0;
         end else if (gap_over) begin
            state <= ST_IDLE;
         end
      end
   end

   assign in_ready = (state == ST_IDLE);
endmodule

// File: rtl/sdac_frame_tx_chk.sv
module sdac_frame_tx_chk #(
   parameter int GAP_CYC = 4
) (
   input logic clk,
   input logic rst,
   input logic abort,
   input logic in_ready,
   input logic sync_n,
   input logic sclk,
   input logic sdo,
   input logic done
);
   int gap_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         gap_cnt <= GAP_CYC + 1;
      else if (!sync_n)
         gap_cnt <= 0;
      else if (gap_cnt < GAP_CYC + 1)
         gap_cnt <= gap_cnt + 1;
   end

   p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> (sync_n && !sclk && !done));

   p_clk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
      sync_n |-> !sclk);

   p_data_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
      (!sync_n && !$stable(sdo)) |-> $rose(sclk));

   p_done_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> ($fell(sclk) && !sync_n));

   p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(sync_n) |-> (gap_cnt >= GAP_CYC + 1));

   p_abort_stop_r8: assert property (@(posedge clk) disable iff (rst)
      (abort && !sync_n) |=> (sync_n && !sclk && !sdo && !done));
endmodule

bind sdac_frame_tx sdac_frame_tx_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .abort    (abort),
   .in_ready (in_ready),
   .sync_n   (sync_n),
   .sclk     (sclk),
   .sdo      (sdo),
   .done     (done)
);

// File: tb/sdac_frame_tx_tb.sv
module sdac_frame_tx_tb;
   localparam int HALF  = 2;
   localparam int SETUP = 3;
   localparam int GAP   = 4;
   localparam int NBITS = 24;
   localparam logic [4:0] IDLE_W = 5'b11000; // {ready,sync_n,sclk,sdo,done}

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [15:0] in_code = '0;
   logic [1:0] in_mode = '0;
   logic abort = 1'b0;
   logic in_ready, sync_n, sclk, sdo, done;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sdac_frame_tx #(
      .HALF_CYC(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP)
   ) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_code(in_code), .in_mode(in_mode), .abort(abort),
      .sync_n(sync_n), .sclk(sclk), .sdo(sdo), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, expv);
      end
   endtask

   // cycle-level reference model: a queue of expected output words
   logic [4:0] q[$];
   logic [4:0] exp_w = IDLE_W;

   function automatic void push_frame(input logic [15:0] c, input logic [1:0] m);
      logic [23:0] w;
      w = {6'b0, m, c};
      for (int i = 0; i < SETUP; i++) q.push_back(5'b00000);
      for (int b = NBITS - 1; b >= 0; b--) begin
         for (int h = 0; h < HALF; h++) q.push_back({3'b001, w[b], 1'b0});
         for (int h = 0; h < HALF; h++) q.push_back({3'b000, w[b], (b == 0 && h == 0)});
      end
      for (int g = 0; g < GAP; g++) q.push_back(5'b01000);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         q.delete();
         exp_w = IDLE_W;
      end else begin
         if (exp_w[4] && in_valid) begin
            q.delete();
            push_frame(in_code, in_mode);
         end else if (abort && !exp_w[3]) begin
            q.delete();
            for (int g = 0; g < GAP; g++) q.push_back(5'b01000);
         end
         if (q.size() > 0) exp_w = q.pop_front();
         else exp_w = IDLE_W;
      end
   end

   // edge monitors
   logic [23:0] cap_word = '0;
   int cap_n = 0;
   int done_cnt = 0;
   logic [23:0] want_word = '0;
   logic prev_sclk = 0, prev_sync = 1;
   int hi_len = 0, lo_len = 0, setup_len = 0, gap_len = 100;
   bit first_rise = 0;

   always @(negedge clk) begin
      if (!rst && !finished) begin
         check(in_ready === exp_w[4], "R2 ready", in_ready, exp_w[4]);
         check(sync_n === exp_w[3], "R5 sync_n", sync_n, exp_w[3]);
         check(sclk === exp_w[2], "R4 sclk", sclk, exp_w[2]);
         check(sdo === exp_w[1], "R1 sdo", sdo, exp_w[1]);
         check(done === exp_w[0], "R6 done", done, exp_w[0]);

         if (prev_sync && !sync_n) begin
            check(gap_len >= GAP + 1, "R7 gap", gap_len, GAP + 1);
            cap_n = 0; setup_len = 0; first_rise = 1;
         end
         if (sync_n) gap_len++; else gap_len = 0;
         if (!sync_n && !sclk && first_rise) setup_len++;
         if (!prev_sclk && sclk) begin
            if (first_rise) check(setup_len == SETUP, "R3 setup", setup_len, SETUP);
            else check(lo_len == HALF, "R4 low phase", lo_len, HALF);
            first_rise = 0; hi_len = 0;
         end
         if (prev_sclk && !sclk && !sync_n) begin
            check(hi_len == HALF, "R4 high phase", hi_len, HALF);
            check(hi_len * 10 >= 13, "R10 phase ns", hi_len * 10, 13);
            cap_word = {cap_word[22:0], sdo};
            cap_n++; lo_len = 0;
         end
         if (sclk) hi_len++; else lo_len++;
         if (done) begin
            done_cnt++;
            check(cap_n == NBITS, "R1 bit count", cap_n, NBITS);
            check(cap_word == want_word, "R1 word", cap_word, want_word);
         end
         prev_sclk = sclk; prev_sync = sync_n;
      end
   end

   task automatic send(input logic [15:0] c, input logic [1:0] m);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_code = c; in_mode = m;
      want_word = {6'b0, m, c};
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
   endtask

   task automatic pulse_abort(input int delay);
      repeat (delay) @(negedge clk);
      abort = 1;
      @(negedge clk);
      abort = 0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 150000 && !finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int d0;
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R11 reset state
      check(sync_n === 1'b1, "R11 sync_n", sync_n, 1);
      check(sclk === 1'b0, "R11 sclk", sclk, 0);
      check(sdo === 1'b0, "R11 sdo", sdo, 0);
      check(done === 1'b0, "R11 done", done, 0);
      check(in_ready === 1'b1, "R11 ready", in_ready, 1);

      // R1 patterns and modes
      send(16'h0000, 2'b00);
      send(16'hFFFF, 2'b11);
      send(16'hA5C3, 2'b01);
      send(16'h8001, 2'b10);
      wait_idle();
      check(done_cnt == 4, "R1 frames done", done_cnt, 4);

      // R2 valid while busy is ignored
      d0 = done_cnt;
      send(16'h1234, 2'b01);
      in_valid = 1; in_code = 16'hDEAD; in_mode = 2'b11;
      repeat (20) @(negedge clk);
      in_valid = 0;
      wait_idle();
      repeat (3) @(negedge clk);
      check(done_cnt == d0 + 1, "R2 busy ignored", done_cnt, d0 + 1);
      check(cap_word == {6'b0, 2'b01, 16'h1234}, "R2 word kept", cap_word, {6'b0, 2'b01, 16'h1234});

      // R8 abort at many offsets through a frame
      for (int k = 0; k < 12; k++) begin
         d0 = done_cnt;
         send(16'h5A5A, 2'b10);
         pulse_abort(k);
         wait_idle();
         check(done_cnt == d0, "R8 abort no done", done_cnt, d0);
      end
      // R8 abort at the final falling edge
      for (int k = SETUP + NBITS * 2 * HALF - HALF - 3; k < SETUP + NBITS * 2 * HALF; k++) begin
         send(16'hC0DE, 2'b01);
         pulse_abort(k);
         wait_idle();
      end

      // R9 abort while gap or idle does nothing
      d0 = done_cnt;
      send(16'h7E81, 2'b00);
      @(negedge clk);
      while (!done) @(negedge clk);
      repeat (HALF + 1) @(negedge clk);
      abort = 1;
      @(negedge clk);
      abort = 0;
      check(sync_n === 1'b1 && !sclk, "R9 gap abort", {sync_n, sclk}, 2'b10);
      wait_idle();
      pulse_abort(2);
      check(in_ready === 1'b1 && sync_n === 1'b1, "R9 idle abort", {in_ready, sync_n}, 2'b11);
      check(done_cnt == d0 + 1, "R9 frame intact", done_cnt, d0 + 1);

      // R7 back-to-back with valid held
      d0 = done_cnt;
      send(16'h0F0F, 2'b11);
      send(16'hF0F0, 2'b00);
      wait_idle();
      repeat (3) @(negedge clk);
      check(done_cnt == d0 + 2, "R7 back to back", done_cnt, d0 + 2);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule